// File: doc/BRIEF.md
# Dynamic Bus Sizing Write Sequencer

This block turns one write request from an internal master into one or more cycles on an external 32-bit data bus. The request can be a long word, three bytes, a word or a single byte. Each bus cycle presents three things: a two-bit transfer size that says how many bytes are still owed, the byte offset of the next unsent byte within its long word, and the data placed on the four byte lanes by a write multiplexer.

The addressed port answers with a two-line acknowledge that also reports its own width. A 32-bit port takes everything that fits in the current long word. A 16-bit port takes data only from the upper half of the bus. An 8-bit port takes data only from the top lane. When the port takes fewer bytes than are still owed, the sequencer does four things:

- it ends the cycle,
- it drops both strobes for one clock,
- it advances the address by the number of bytes taken,
- it starts a follow-on cycle with a smaller size code and the remaining bytes steered onto the lanes that a narrow port reads.

The master sees one done pulse when the last byte has been taken.

Top module: `bsz_write_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `bus_as`, `bus_ds` and `done` are 0. While the block is idle, no strobe is asserted.
- R2: `bus_siz` encodes the bytes still owed: 00 means four, 01 means one, 10 means two and 11 means three. `bus_addr` is the address of the next unsent byte, and its bits [1:0] give the byte offset. The first cycle carries the requested size and address.
- R3: An acknowledge of 11 (32-bit port) takes min(owed, 4 − offset) bytes. An aligned long word therefore completes in one cycle.
- R4: An acknowledge of 10 (16-bit port) takes min(owed, 2 − offset[0]) bytes. An aligned long word takes two cycles. The second cycle has size 10 and offset 2, and carries the two least significant operand bytes on D31–D16.
- R5: An acknowledge of 01 (8-bit port) takes one byte per cycle. Each follow-on cycle places the next unsent byte on D31–D24 and advances the address by one.
- R6: While the acknowledge is 00, the cycle is held. The strobes stay asserted, and the address, size and data stay unchanged.
- R7: Lane steering. Lanes are numbered 0 (D31–D24) to 3 (D7–D0), and the operand is given most significant byte first. Unsent byte i is driven on lane offset + i. In addition, the first unsent byte is copied to lane 0. At offset 2, bytes 0 and 1 are also copied to lanes 0 and 1. At offset 3, byte 0 is also copied to lane 1.
- R8: `done` is a one-clock pulse in the clock after the acknowledge that took the last byte. `req_ready` is 0 while a request is in progress, and a `req_valid` that arrives during that time is ignored.
- R9: Between two cycles of the same request, `bus_as` and `bus_ds` are low for at least one clock.
- R10: A transfer that runs past the end of its long word continues at the next long-word base, because the address always advances by the number of bytes taken.
- R11: The request operand `req_data` is right-justified. A long word uses bits [31:0], three bytes use [23:0], a word uses [15:0] and a byte uses [7:0]. The most significant byte goes to the lowest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present (taken when `req_ready` is 1) |
| req_ready | output | 1 | Block idle, able to take a request |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand size code (R2 encoding) |
| req_data | input | 32 | Right-justified operand |
| done | output | 1 | One-clock pulse after the final byte is taken |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_siz | output | 2 | Remaining-size code of the current cycle |
| bus_data | output | 32 | Steered write data |
| bus_as | output | 1 | Address strobe, high during a cycle |
| bus_ds | output | 1 | Data strobe, high during a cycle |
| port_ack | input | 2 | Width acknowledge: 11 is 32-bit, 10 is 16-bit, 01 is 8-bit, 00 is wait |

## Verification
A wrong owed-byte count shows up in the very next cycle as a wrong size code. It also changes the number of cycles, so the done pulse comes too early or too late. A wrong address step shows up at the next strobe as a wrong offset. It also makes bytes land at the wrong locations in the port model's memory. A steering fault leaves a wrong byte in that memory as soon as the affected cycle is acknowledged. The bench models ports of each width at every starting offset, and compares the cycle count, the size and offset of each cycle, and the bytes delivered against a sequence it computes itself.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_t;

  localparam logic [1:0] ACK_WAIT = 2'b00;
  localparam logic [1:0] ACK_P8   = 2'b01;
  localparam logic [1:0] ACK_P16  = 2'b10;
  localparam logic [1:0] ACK_P32  = 2'b11;

  // size code -> byte count (00 stands for four)
  function automatic logic [2:0] siz_bytes(input logic [1:0] s);
    return (s == 2'b00) ? 3'd4 : {1'b0, s};
  endfunction

  // byte count (1..4) -> size code
  function automatic logic [1:0] bytes_siz(input logic [2:0] n);
    return n[1:0];
  endfunction

  // bytes a port of the acknowledged width can take at this offset
  function automatic logic [2:0] accept_cnt(input logic [1:0] ack,
                                            input logic [1:0] off,
                                            input logic [2:0] owed);
    logic [2:0] room;
    case (ack)
      ACK_P32: room = 3'd4 - {1'b0, off};
      ACK_P16: room = 3'd2 - {2'b00, off[0]};
      ACK_P8:  room = 3'd1;
      default: room = 3'd0;
    endcase
    return (owed < room) ? owed : room;
  endfunction

  // which unsent byte index feeds a given lane at a given offset
  function automatic logic [1:0] lane_src(input logic [1:0] lane,
                                          input logic [1:0] off);
    if (lane >= off)
      return lane - off;
    else if (off[1] && (lane[0] >= off[0]))
      return {1'b0, lane[0] & ~off[0]};
    else
      return 2'd0;
  endfunction

endpackage

// File: rtl/bsz_lane_mux.sv
module bsz_lane_mux
  import bsz_pkg::*;
(
  input  logic [DATA_W-1:0] opr,
  input  logic [2:0]        owed,
  input  logic [1:0]        off,
  output logic [DATA_W-1:0] lanes
);

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    logic [1:0]        src;
    logic [7:0]        lane_byte;
    logic [DATA_W-1:0] shifted;
    int                sh_amt;

    always_comb begin
      src       = lane_src(2'(L), off);
      sh_amt    = 0;
      shifted   = '0;
      lane_byte = 8'h00;
      if ({1'b0, src} < owed) begin
        sh_amt    = 8 * (int'(owed) - 1 - int'(src));
        shifted   = opr >> sh_amt;
        lane_byte = shifted[7:0];
      end
    end

    assign lanes[DATA_W-1-8*L -: 8] = lane_byte;
  end

endmodule

// File: rtl/bsz_accept.sv
module bsz_accept
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        ack,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        owed,
  output logic [2:0]        taken,
  output logic [2:0]        owed_nxt,
  output logic [ADDR_W-1:0] addr_nxt
);

  always_comb begin
    taken    = accept_cnt(ack, addr[1:0], owed);
    owed_nxt = owed - taken;
    addr_nxt = addr + ADDR_W'(taken);
  end

endmodule

// File: rtl/bsz_seq_ctrl.sv
module bsz_seq_ctrl
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        ack,
  input  logic [2:0]        taken,
  input  logic [2:0]        owed_nxt,
  input  logic [ADDR_W-1:0] addr_nxt,
  output logic [ADDR_W-1:0] addr_q,
  output logic [2:0]        owed_q,
  output logic [DATA_W-1:0] opr_q,
  output logic              cyc_on,
  output logic              idle,
  output logic              done
);

  seq_state_t state;

  // named events for the checks
  logic ev_accept;
  logic ev_last;
  assign ev_accept = (state == ST_DRIVE) && (taken != 3'd0);
  assign ev_last   = ev_accept && (owed_nxt == 3'd0);

  assign cyc_on = (state == ST_DRIVE);
  assign idle   = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      owed_q <= 3'd0;
      opr_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            owed_q <= siz_bytes(req_size);
            opr_q  <= req_data;
            state  <= ST_DRIVE;
          end
        end
        ST_DRIVE: begin
          if (ev_accept) begin
            addr_q <= addr_nxt;
            owed_q <= owed_nxt;
            if (ev_last) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_GAP;
            end
          end
        end
        ST_GAP:  state <= ST_DRIVE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: strobes drop after every acknowledged cycle
  p_gap_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !cyc_on);

  // R6: a wait acknowledge holds the cycle unchanged
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_on && ack == ACK_WAIT) |=> (cyc_on && $stable(addr_q) && $stable(owed_q)));

  // R8: done is a single-clock pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done only follows an acknowledged final cycle
  p_done_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cyc_on && ack != ACK_WAIT));

  // R1: no strobe while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !cyc_on);

  // R2: an active cycle never owes zero bytes
  p_owed_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_on |-> (owed_q != 3'd0 && owed_q <= 3'd4));

endmodule

// File: rtl/bsz_write_seq.sv
module bsz_write_seq
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_data,
  output logic              done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [31:0]       bus_data,
  output logic              bus_as,
  output logic              bus_ds,
  input  logic [1:0]        port_ack
);

  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [2:0]        owed_q, owed_nxt, taken;
  logic [DATA_W-1:0] opr_q;
  logic              cyc_on, idle;
  logic [1:0]        ack_eff;

  // an acknowledge only counts during an active cycle
  assign ack_eff = cyc_on ? port_ack : ACK_WAIT;

  bsz_accept #(.ADDR_W(ADDR_W)) u_accept (
    .ack      (ack_eff),
    .addr     (addr_q),
    .owed     (owed_q),
    .taken    (taken),
    .owed_nxt (owed_nxt),
    .addr_nxt (addr_nxt)
  );

  bsz_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_data  (req_data),
    .ack       (ack_eff),
    .taken     (taken),
    .owed_nxt  (owed_nxt),
    .addr_nxt  (addr_nxt),
    .addr_q    (addr_q),
    .owed_q    (owed_q),
    .opr_q     (opr_q),
    .cyc_on    (cyc_on),
    .idle      (idle),
    .done      (done)
  );

  bsz_lane_mux u_mux (
    .opr   (opr_q),
    .owed  (owed_q),
    .off   (addr_q[1:0]),
    .lanes (bus_data)
  );

  assign req_ready = idle;
  assign bus_addr  = addr_q;
  assign bus_siz   = bytes_siz(owed_q);
  assign bus_as    = cyc_on;
  assign bus_ds    = cyc_on;

  // R5: a byte acknowledge advances the address by exactly one
  p_byte_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && port_ack == ACK_P8) |=> (bus_addr == $past(bus_addr) + ADDR_W'(1)));

  // R8: no new request is taken while busy
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !(bus_as && port_ack != ACK_WAIT)) |=> $stable(bus_addr));

endmodule

// File: tb/bsz_write_seq_tb.sv
module bsz_write_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_data = '0;
  logic        done;
  logic [31:0] bus_addr;
  logic [1:0]  bus_siz;
  logic [31:0] bus_data;
  logic        bus_as, bus_ds;
  logic [1:0]  port_ack = 2'b00;

  always #10 clk = ~clk;  // 50 MHz

  bsz_write_seq #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_data(req_data), .done(done),
    .bus_addr(bus_addr), .bus_siz(bus_siz), .bus_data(bus_data),
    .bus_as(bus_as), .bus_ds(bus_ds), .port_ack(port_ack)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- port model ----------------
  int          port_w = 32;
  int          port_waits = 0;
  int          wcnt = 0;
  logic [7:0]  mem [64];
  logic [1:0]  rec_siz [16];
  logic [1:0]  rec_off [16];
  logic [31:0] rec_data [16];
  int          rec_cnt = 0;
  int          done_cnt = 0;
  logic [31:0] w_addr, w_data;
  logic [1:0]  w_siz;
  bit          saw_gap_fail = 0;
  bit          prev_as = 0;

  always @(negedge clk) begin : port_model
    int n, off, acc, first;
    if (done) done_cnt++;
    if (port_ack != 2'b00) begin
      port_ack = 2'b00;
    end else if (bus_as) begin
      if (wcnt == 0) begin
        w_addr = bus_addr; w_siz = bus_siz; w_data = bus_data;
      end else begin
        chk(bus_addr == w_addr && bus_siz == w_siz && bus_data == w_data && bus_ds,
            "R6", "held cycle changed", bus_addr, w_addr);
      end
      if (wcnt < port_waits) begin
        wcnt++;
      end else begin
        n   = (bus_siz == 2'b00) ? 4 : int'(bus_siz);
        off = int'(bus_addr[1:0]);
        case (port_w)
          32: begin acc = (n < 4 - off) ? n : 4 - off; first = off; end
          16: begin acc = (n < 2 - off % 2) ? n : 2 - off % 2; first = off % 2; end
          default: begin acc = 1; first = 0; end
        endcase
        for (int k = 0; k < acc; k++)
          mem[(int'(bus_addr[5:0]) + k) % 64] = bus_data[31 - 8 * (first + k) -: 8];
        if (rec_cnt < 16) begin
          rec_siz[rec_cnt]  = bus_siz;
          rec_off[rec_cnt]  = bus_addr[1:0];
          rec_data[rec_cnt] = bus_data;
        end
        rec_cnt++;
        wcnt = 0;
        port_ack = (port_w == 32) ? 2'b11 : (port_w == 16) ? 2'b10 : 2'b01;
      end
    end
    // R9: a new strobe never directly follows an acknowledged one
    if (bus_as && prev_as && wcnt == 0 && port_ack == 2'b00) saw_gap_fail = 1;
    prev_as = bus_as;
  end

  function automatic int sz_n(input logic [1:0] s);
    case (s)
      2'b00: return 4;
      2'b01: return 1;
      2'b10: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] n_sz(input int n);
    case (n)
      4: return 2'b00;
      1: return 2'b01;
      2: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  endtask

  task automatic send(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int start, input string tag);
    for (int i = 0; i < 400; i++) begin
      if (done_cnt > start) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == start + 1, "R8", {tag, " done pulses"}, done_cnt - start, 1);
    chk(req_ready && !bus_as && !bus_ds, "R8", {tag, " idle after done"},
        {req_ready, bus_as, bus_ds}, 3'b100);
  endtask

  // generic transfer: all the cycle, size, offset and byte checks
  task automatic t_xfer(input int pw, input logic [1:0] off, input logic [1:0] sz,
                        input logic [31:0] data, input int waits);
    int n, rem, a, k, acc, o, start;
    logic [1:0] e_siz [16];
    logic [1:0] e_off [16];
    logic [31:0] base;
    string tag;
    base = 32'h0000_1020 + {30'd0, off};
    tag  = $sformatf("pw%0d off%0d sz%0d", pw, off, sz);
    n = sz_n(sz);
    rem = n; a = int'(base); k = 0;
    while (rem > 0) begin
      o = a % 4;
      e_siz[k] = n_sz(rem);
      e_off[k] = 2'(o);
      if (pw == 32)      acc = (rem < 4 - o) ? rem : 4 - o;
      else if (pw == 16) acc = (rem < 2 - o % 2) ? rem : 2 - o % 2;
      else               acc = 1;
      a += acc; rem -= acc; k++;
    end
    clear_mem();
    port_w = pw; port_waits = waits; rec_cnt = 0; saw_gap_fail = 0;
    start = done_cnt;
    send(base, sz, data);
    wait_done(start, tag);
    chk(rec_cnt == k, pw == 32 ? "R3" : pw == 16 ? "R4" : "R5",
        {tag, " cycle count"}, rec_cnt, k);
    for (int c = 0; c < k && c < rec_cnt; c++) begin
      chk(rec_siz[c] == e_siz[c], "R2", $sformatf("%s cyc%0d size", tag, c), rec_siz[c], e_siz[c]);
      chk(rec_off[c] == e_off[c], "R10", $sformatf("%s cyc%0d offset", tag, c), rec_off[c], e_off[c]);
    end
    for (int i = 0; i < n; i++) begin
      logic [7:0] eb;
      eb = 8'(data >> (8 * (n - 1 - i)));
      chk(mem[(int'(base[5:0]) + i) % 64] == eb, "R7", $sformatf("%s byte%0d (R11 order)", tag, i),
          mem[(int'(base[5:0]) + i) % 64], eb);
    end
    chk(!saw_gap_fail, "R9", {tag, " strobe gap"}, saw_gap_fail, 0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(!bus_as && !bus_ds, "R1", "strobes after reset", {bus_as, bus_ds}, 0);
    chk(!done, "R1", "done after reset", done, 0);
  endtask

  // R4: aligned long word to a 16-bit port, second cycle details
  task automatic t_long_on_word_port();
    t_xfer(16, 2'd0, 2'b00, 32'hA1B2_C3D4, 0);
    chk(rec_siz[1] == 2'b10 && rec_off[1] == 2'd2, "R4", "second cycle size/offset",
        {rec_siz[1], rec_off[1]}, 4'b1010);
    chk(rec_data[1][31:16] == 16'hC3D4, "R4", "low half on D31-D16",
        rec_data[1][31:16], 16'hC3D4);
    chk(rec_data[0] == 32'hA1B2_C3D4, "R4", "first cycle all lanes", rec_data[0], 32'hA1B2_C3D4);
  endtask

  // R5: byte port, top lane carries each next byte
  task automatic t_byte_port_lanes();
    t_xfer(8, 2'd1, 2'b11, 32'h0055_6677, 0);
    chk(rec_data[0][31:24] == 8'h55 && rec_data[1][31:24] == 8'h66 && rec_data[2][31:24] == 8'h77,
        "R5", "top lane sequence",
        {rec_data[0][31:24], rec_data[1][31:24], rec_data[2][31:24]}, 24'h556677);
  endtask

  // R6: wait states
  task automatic t_waits();
    t_xfer(16, 2'd1, 2'b00, 32'h1357_9BDF, 3);
    t_xfer(32, 2'd3, 2'b10, 32'h0000_ABCD, 2);
  endtask

  // R8: requests during a busy transfer are ignored
  task automatic t_busy_ignore();
    int start;
    clear_mem();
    port_w = 8; port_waits = 1; rec_cnt = 0;
    start = done_cnt;
    send(32'h0000_1000, 2'b00, 32'hDEAD_BEEF);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0000_1010; req_size = 2'b00; req_data = 32'h1111_2222;
    end
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(start, "busy");
    chk(rec_cnt == 4, "R8", "busy: cycles of first request", rec_cnt, 4);
    chk({mem[0], mem[1], mem[2], mem[3]} == 32'hDEAD_BEEF, "R8", "busy: first operand",
        {mem[0], mem[1], mem[2], mem[3]}, 32'hDEAD_BEEF);
    chk({mem[16], mem[17], mem[18], mem[19]} == 32'h0, "R8", "busy: second request ignored",
        {mem[16], mem[17], mem[18], mem[19]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_long_on_word_port();
    t_byte_port_lanes();
    t_waits();
    t_busy_ignore();
    // sweep: every port width, offset and size (R3/R4/R5/R7/R10)
    for (int pw = 0; pw < 3; pw++)
      for (int o = 0; o < 4; o++)
        for (int s = 0; s < 4; s++)
          t_xfer(pw == 0 ? 32 : pw == 1 ? 16 : 8, 2'(o), 2'(s),
                 32'h8192_A3B4 ^ (o * 32'h0101_0101) ^ (s * 32'h1000_0010), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule